// File: doc/BRIEF.md
# Receive-Pending Flags with Interrupt Gathering

This block keeps one pending bit for each receive mailbox of a CAN-style mailbox controller. When the receive path reports that a data frame has been written into mailbox n, bit n goes high. The bit goes high only if that mailbox is set up to take data frames. Software reads all the bits as one word. It acknowledges a frame by writing a one to the matching bit position.

The pending bits are also collected into a single frame-received interrupt flag. A mailbox can raise this flag only while its own interrupt mask bit is clear. A separate global mask bit then decides whether the flag reaches the interrupt output. The flag stays high while at least one pending bit with a clear mask is still set. It falls in the same clock edge that removes the last such bit.

Top module: `rx_pend_reg`

## Requirements
- R1: After reset, every pending bit, the interrupt flag and the interrupt output are 0.
- R2: A store strobe with the frame-kind input at 0 (data frame) and a mailbox index whose receive-enable bit is 1 sets pending bit `store_idx` at the next clock edge.
- R3: A store strobe aimed at a mailbox whose receive-enable bit is 0 leaves every pending bit unchanged.
- R4: A store strobe with the frame-kind input at 1 (remote frame) leaves every pending bit unchanged, even for a receive-enabled mailbox.
- R5: A register write clears, at the next edge, each pending bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R6: If a qualified store and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R7: `reg_rd_data` always shows the current pending bits, bit n for mailbox n.
- R8: A qualified store to a mailbox whose interrupt mask bit (1 = masked) is 0 sets the interrupt flag at the same edge that sets the pending bit. A store to a masked mailbox does not raise the flag.
- R9: Once set, the interrupt flag stays high while any pending bit with a clear mask bit remains. It drops at the edge where the last such bit is cleared, even if pending bits of masked mailboxes remain.
- R10: `rx_irq` is high exactly when the interrupt flag is high and `glb_rx_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_vld | input | 1 | A frame has been stored in a mailbox this cycle |
| store_idx | input | 4 | Mailbox that received the frame |
| store_kind | input | 1 | 0 = data frame, 1 = remote frame |
| mbx_rx_en | input | 16 | Per-mailbox: 1 = configured to receive data frames |
| mbx_irq_mask | input | 16 | Per-mailbox interrupt mask, 1 = masked |
| glb_rx_mask | input | 1 | Global mask of the received interrupt, 1 = masked |
| reg_wr_en | input | 1 | Write strobe for the pending register |
| reg_wr_data | input | 16 | Write data, 1 bits clear the matching flags |
| reg_rd_data | output | 16 | Current pending bits |
| rx_irq_flag | output | 1 | Shared frame-received interrupt flag |
| rx_irq | output | 1 | Interrupt output after the global mask |

## Verification
The assertions assume that `store_idx` names a mailbox that exists and that the store inputs are known whenever `store_vld` is high. The bench drives only indices from 0 to 15 and holds every input steady across each clock edge. The interrupt-flag checks assume that the mailbox mask inputs do not change in the same cycle as a store. For that reason the bench changes masks and receive enables only in cycles with no store and no write.

// File: rtl/rx_pend_pkg.sv
package rx_pend_pkg;
  typedef enum logic {
    FRM_DATA   = 1'b0,
    FRM_REMOTE = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/rx_pend_qual.sv
module rx_pend_qual #(
  parameter int NUM_MBX = 16,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_vld,
  input  logic [IDX_W-1:0]   store_idx,
  input  logic               store_kind,
  input  logic [NUM_MBX-1:0] mbx_rx_en,
  output logic [NUM_MBX-1:0] set_vec
);
  import rx_pend_pkg::*;

  function automatic logic [NUM_MBX-1:0] idx_to_bit(input logic [IDX_W-1:0] idx);
    logic [NUM_MBX-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (idx == IDX_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  logic is_data;
  assign is_data = (frame_kind_e'(store_kind) == FRM_DATA);
  assign set_vec = (store_vld && is_data) ? (idx_to_bit(store_idx) & mbx_rx_en) : '0;

  // R2
  set_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set_vec));
  // R4
  remote_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_vld && store_kind) |-> (set_vec == '0));
endmodule

// File: rtl/rx_pend_bits.sv
module rx_pend_bits #(
  parameter int NUM_MBX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] set_vec,
  input  logic               wr_en,
  input  logic [NUM_MBX-1:0] wr_data,
  output logic [NUM_MBX-1:0] flags_q,
  output logic [NUM_MBX-1:0] flags_nxt
);
  logic [NUM_MBX-1:0] clr_vec;
  assign clr_vec = wr_en ? wr_data : '0;

  for (genvar g = 0; g < NUM_MBX; g++) begin : g_bit
    // set beats clear
    assign flags_nxt[g] = set_vec[g] | (flags_q[g] & ~clr_vec[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= flags_nxt[g];
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> flags_q[g]);
    // R5
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> !flags_q[g]);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[g] && !set_vec[g]) |=> $stable(flags_q[g]));
  end
endmodule

// File: rtl/rx_pend_irq.sv
module rx_pend_irq #(
  parameter int NUM_MBX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] set_vec,
  input  logic [NUM_MBX-1:0] flags_nxt,
  input  logic [NUM_MBX-1:0] mbx_irq_mask,
  input  logic               glb_rx_mask,
  output logic               irq_flag_q,
  output logic               irq_o
);
  function automatic logic any_open(input logic [NUM_MBX-1:0] f,
                                    input logic [NUM_MBX-1:0] m);
    return |(f & ~m);
  endfunction

  logic raise_evt;
  logic keep_evt;
  assign raise_evt = any_open(set_vec, mbx_irq_mask);
  assign keep_evt  = irq_flag_q & any_open(flags_nxt, mbx_irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag_q <= 1'b0;
    else        irq_flag_q <= raise_evt | keep_evt;
  end

  assign irq_o = irq_flag_q & ~glb_rx_mask;

  // R8
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n) raise_evt |=> irq_flag_q);
  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_q) |-> $past(raise_evt));
  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_evt && !any_open(flags_nxt, mbx_irq_mask)) |=> !irq_flag_q);
endmodule

// File: rtl/rx_pend_reg.sv
module rx_pend_reg #(
  parameter int NUM_MBX = 16,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_vld,
  input  logic [IDX_W-1:0]   store_idx,
  input  logic               store_kind,
  input  logic [NUM_MBX-1:0] mbx_rx_en,
  input  logic [NUM_MBX-1:0] mbx_irq_mask,
  input  logic               glb_rx_mask,
  input  logic               reg_wr_en,
  input  logic [NUM_MBX-1:0] reg_wr_data,
  output logic [NUM_MBX-1:0] reg_rd_data,
  output logic               rx_irq_flag,
  output logic               rx_irq
);
  logic [NUM_MBX-1:0] set_vec;
  logic [NUM_MBX-1:0] flags_q;
  logic [NUM_MBX-1:0] flags_nxt;

  rx_pend_qual #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .store_vld(store_vld), .store_idx(store_idx),
    .store_kind(store_kind), .mbx_rx_en(mbx_rx_en), .set_vec(set_vec)
  );

  rx_pend_bits #(.NUM_MBX(NUM_MBX)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(reg_wr_en),
    .wr_data(reg_wr_data), .flags_q(flags_q), .flags_nxt(flags_nxt)
  );

  rx_pend_irq #(.NUM_MBX(NUM_MBX)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .flags_nxt(flags_nxt),
    .mbx_irq_mask(mbx_irq_mask), .glb_rx_mask(glb_rx_mask),
    .irq_flag_q(rx_irq_flag), .irq_o(rx_irq)
  );

  // R7
  assign reg_rd_data = flags_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (reg_rd_data == '0 && !rx_irq_flag));
endmodule

// File: tb/rx_pend_reg_tb.sv
module rx_pend_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        store_vld = 1'b0;
  logic [3:0]  store_idx = '0;
  logic        store_kind = 1'b0;
  logic [15:0] mbx_rx_en = 16'h7FFF;
  logic [15:0] mbx_irq_mask = 16'h0010;
  logic        glb_rx_mask = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        rx_irq_flag;
  logic        rx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_pend_reg u_dut (
    .clk(clk), .rst_n(rst_n), .store_vld(store_vld), .store_idx(store_idx),
    .store_kind(store_kind), .mbx_rx_en(mbx_rx_en), .mbx_irq_mask(mbx_irq_mask),
    .glb_rx_mask(glb_rx_mask), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .rx_irq_flag(rx_irq_flag), .rx_irq(rx_irq)
  );

  // vector: vld, idx[4], kind, wr, wdata[16], exp_flags[16], exp_irqf
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 4'd0,  1'b0, 1'b0, 16'h0000, 16'h0001, 1'b1},  // R2 R8
    {1'b1, 4'd4,  1'b0, 1'b0, 16'h0000, 16'h0011, 1'b1},  // R2 masked mbx
    {1'b1, 4'd2,  1'b1, 1'b0, 16'h0000, 16'h0011, 1'b1},  // R4 remote
    {1'b1, 4'd15, 1'b0, 1'b0, 16'h0000, 16'h0011, 1'b1},  // R3 not enabled
    {1'b0, 4'd0,  1'b0, 1'b1, 16'h0001, 16'h0010, 1'b0},  // R5 R9 masked left
    {1'b1, 4'd7,  1'b0, 1'b1, 16'h0080, 16'h0090, 1'b1},  // R6
    {1'b0, 4'd0,  1'b0, 1'b1, 16'h0000, 16'h0090, 1'b1},  // R5 write 0
    {1'b0, 4'd0,  1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0},  // R5 R9
    {1'b1, 4'd9,  1'b0, 1'b0, 16'h0000, 16'h0200, 1'b1},  // R2
    {1'b1, 4'd4,  1'b0, 1'b0, 16'h0000, 16'h0210, 1'b1},  // R9 stays
    {1'b0, 4'd0,  1'b0, 1'b1, 16'h0200, 16'h0010, 1'b0},  // R9 drop
    {1'b1, 4'd4,  1'b0, 1'b0, 16'h0000, 16'h0010, 1'b0}   // R8 masked no raise
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    store_vld = 1'b0;
    reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 flags in reset", reg_rd_data, 16'h0);
    check("R1 irq flag in reset", {15'b0, rx_irq_flag}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", reg_rd_data, 16'h0);
    check("R1 irq after reset", {15'b0, rx_irq}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      store_vld   = VEC[i][39];
      store_idx   = VEC[i][38:35];
      store_kind  = VEC[i][34];
      reg_wr_en   = VEC[i][33];
      reg_wr_data = VEC[i][32:17];
      cycle();
      check($sformatf("R7 R2-R6 vec%0d flags", i), reg_rd_data, VEC[i][16:1]);
      check($sformatf("R8 R9 vec%0d irq flag", i), {15'b0, rx_irq_flag}, {15'b0, VEC[i][0]});
      check($sformatf("R10 vec%0d irq", i), {15'b0, rx_irq}, {15'b0, VEC[i][0]});
    end

    // R10 global mask gating
    store_vld = 1'b1; store_idx = 4'd3; store_kind = 1'b0;
    cycle();
    check("R2 mbx3 set", reg_rd_data, 16'h0018);
    glb_rx_mask = 1'b1;
    #1;
    check("R10 masked irq low", {15'b0, rx_irq}, 16'h0);
    check("R10 flag still high", {15'b0, rx_irq_flag}, 16'h1);
    glb_rx_mask = 1'b0;
    #1;
    check("R10 unmasked irq high", {15'b0, rx_irq}, 16'h1);

    // R7 repeated reads unchanged
    cycle();
    check("R7 read stable", reg_rd_data, 16'h0018);

    // R3 disable mbx3 then store there again after clearing
    reg_wr_en = 1'b1; reg_wr_data = 16'h0008;
    cycle();
    check("R9 drop after mbx3 clear", {15'b0, rx_irq_flag}, 16'h0);
    mbx_rx_en = 16'hFFF7;
    cycle();
    store_vld = 1'b1; store_idx = 4'd3; store_kind = 1'b0;
    cycle();
    check("R3 disabled mbx3 ignored", reg_rd_data, 16'h0010);
    check("R3 no irq", {15'b0, rx_irq_flag}, 16'h0);

    // R4 remote to enabled mbx 5
    store_vld = 1'b1; store_idx = 4'd5; store_kind = 1'b1;
    cycle();
    check("R4 remote ignored", reg_rd_data, 16'h0010);

    // R1 reset mid-run
    store_vld = 1'b1; store_idx = 4'd12; store_kind = 1'b0;
    cycle();
    check("R2 mbx12 set", reg_rd_data, 16'h1010);
    rst_n = 1'b0;
    #1;
    check("R1 async reset flags", reg_rd_data, 16'h0);
    check("R1 async reset irq", {15'b0, rx_irq_flag}, 16'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule